// File: doc/BRIEF.md
# Modulo-Wrapped Loadable Binary Counter

A synchronous up-counter with a parameterised width (4 bits by default). On each rising clock edge it does one of four things. It clears to zero, loads a parallel word, counts up by one, or holds its value. An active-low clear has the highest priority. An active-low load comes next, and counting comes last. Counting needs two separate enables to both be high. A carry output marks the all-ones state. It is gated by the second enable so that wider chains could use it.

Around the counter sits a terminal-state decoder. When the count equals `MODULUS-1` (14 by default), a flag rises. The flag is fed back into the synchronous clear, so the next edge returns the count to zero. From zero, the counter therefore runs 0 to 14 and wraps, which gives a modulus of 15. A parameter can remove the feedback, and the block then becomes a plain full-range counter.

Top module: `modwrap_counter`

## Requirements
- R1: When `clear_n` is 0 at a rising edge, `q` becomes 0 on that edge, whatever `load_n`, the enables and `din` are.
- R2: When `clear_n` is 1, `load_n` is 0 and `wrap_flag` is 0, `q` takes the value of `din` at the edge, even with both enables low.
- R3: When clear and load are inactive, `wrap_flag` is 0 and either `en_par` or `en_trk` is 0, `q` keeps its value.
- R4: When `clear_n`, `load_n`, `en_par` and `en_trk` are all 1 and `wrap_flag` is 0, `q` increments by one. All ones (15) rolls over to 0.
- R5: `carry_out` is 1 exactly when `q` is all ones and `en_trk` is 1. It follows the inputs within the same cycle.
- R6: `wrap_flag` is 1 exactly when `q` equals `MODULUS-1` (14). While it is 1, the next edge sets `q` to 0 even if load is active or the enables are low.
- R7: Starting from 0 with both enables high, `q` follows 0,1,…,14,0,… and repeats with period 15.
- R8: A value loaded above the terminal state (15) does not raise `wrap_flag`. Counting from it rolls over to 0 and then follows the modulo-15 sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_par | input | 1 | Count enable that does not gate the carry |
| en_trk | input | 1 | Count enable that also gates the carry |
| din | input | W | Parallel load value |
| q | output | W | Registered count |
| carry_out | output | 1 | All-ones and `en_trk` indication |
| wrap_flag | output | 1 | Terminal state (`MODULUS-1`) decode, fed back to the clear |

## Verification
Each control stimulus changes `q` on the first rising edge after it is applied. The driver therefore pushes the expected count into a queue when it drives the inputs on a falling edge. The monitor pops that entry 2 ns after the next rising edge and compares it. `carry_out` and `wrap_flag` are combinational from `q` and `en_trk`, so they are checked in the same cycle, 1 ns after the inputs settle. The cases covered are clear beating load, load with enables low, and the terminal state beating load. The run ends with 100 consecutive counting cycles against the modulo-15 sequence.

// File: rtl/cntw_pkg.sv
package cntw_pkg;

  // Operation chosen for the next clock edge.
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_t;

  // Priority resolution: clear, then load, then count, otherwise hold.
  function automatic cnt_op_t pick_op(input logic clr_n, input logic ld_n,
                                      input logic ep, input logic et);
    cnt_op_t op;
    if (!clr_n)         op = OP_CLEAR;
    else if (!ld_n)     op = OP_LOAD;
    else if (ep && et)  op = OP_COUNT;
    else                op = OP_HOLD;
    return op;
  endfunction

endpackage

// File: rtl/cntw_ctrl.sv
module cntw_ctrl
  import cntw_pkg::*;
(
  input  logic    clr_eff_n,
  input  logic    load_n,
  input  logic    en_par,
  input  logic    en_trk,
  output cnt_op_t op
);
  always_comb op = pick_op(clr_eff_n, load_n, en_par, en_trk);
endmodule

// File: rtl/cntw_reg.sv
module cntw_reg
  import cntw_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  cnt_op_t      op,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    case (op)
      OP_CLEAR: q <= '0;
      OP_LOAD:  q <= din;
      OP_COUNT: q <= q + 1'b1;
      default:  q <= q;
    endcase
  end
endmodule

// File: rtl/cntw_term.sv
module cntw_term #(
  parameter int W       = 4,
  parameter int MODULUS = 15,
  parameter bit WRAP_EN = 1'b1
) (
  input  logic [W-1:0] q,
  input  logic         en_trk,
  output logic         carry_out,
  output logic         wrap_flag
);
  localparam logic [W-1:0] TERM = W'(MODULUS - 1);

  assign carry_out = (&q) & en_trk;

  generate
    if (WRAP_EN) begin : g_wrap
      assign wrap_flag = (q == TERM);
    end else begin : g_nowrap
      assign wrap_flag = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/modwrap_counter.sv
module modwrap_counter
  import cntw_pkg::*;
#(
  parameter int W       = 4,
  parameter int MODULUS = 15,
  parameter bit WRAP_EN = 1'b1
) (
  input  logic         clk,
  input  logic         clear_n,
  input  logic         load_n,
  input  logic         en_par,
  input  logic         en_trk,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         carry_out,
  output logic         wrap_flag
);
  // Terminal-state feedback merged into the synchronous clear.
  logic    clr_eff_n;
  cnt_op_t op;

  assign clr_eff_n = clear_n & ~wrap_flag;

  cntw_ctrl u_ctrl (
    .clr_eff_n (clr_eff_n),
    .load_n    (load_n),
    .en_par    (en_par),
    .en_trk    (en_trk),
    .op        (op)
  );

  cntw_reg #(.W(W)) u_reg (
    .clk (clk),
    .op  (op),
    .din (din),
    .q   (q)
  );

  cntw_term #(.W(W), .MODULUS(MODULUS), .WRAP_EN(WRAP_EN)) u_term (
    .q         (q),
    .en_trk    (en_trk),
    .carry_out (carry_out),
    .wrap_flag (wrap_flag)
  );
endmodule

// File: rtl/modwrap_counter_chk.sv
module modwrap_counter_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         clear_n,
  input logic         load_n,
  input logic         en_par,
  input logic         en_trk,
  input logic [W-1:0] din,
  input logic [W-1:0] q,
  input logic         carry_out,
  input logic         wrap_flag
);
  // Checks start once a clear has defined the count.
  logic armed = 1'b0;
  always_ff @(posedge clk) if (!clear_n || wrap_flag) armed <= 1'b1;

  // R1
  clear_chk: assert property (@(posedge clk) disable iff (!armed)
    !clear_n |=> (q == '0));

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!armed)
    (clear_n && !load_n && !wrap_flag) |=> (q == $past(din)));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!armed)
    (clear_n && load_n && !wrap_flag && !(en_par && en_trk)) |=> $stable(q));

  // R4
  incr_chk: assert property (@(posedge clk) disable iff (!armed)
    (clear_n && load_n && en_par && en_trk && !wrap_flag) |=> (q == $past(q) + 1'b1));

  // R5
  carry_chk: assert property (@(posedge clk) disable iff (!armed)
    carry_out |-> ((&q) && en_trk));

  // R5
  carry_gate_chk: assert property (@(posedge clk) disable iff (!armed)
    !en_trk |-> !carry_out);

  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!armed)
    wrap_flag |=> (q == '0));
endmodule

bind modwrap_counter modwrap_counter_chk #(.W(W)) u_chk (
  .clk       (clk),
  .clear_n   (clear_n),
  .load_n    (load_n),
  .en_par    (en_par),
  .en_trk    (en_trk),
  .din       (din),
  .q         (q),
  .carry_out (carry_out),
  .wrap_flag (wrap_flag)
);

// File: tb/modwrap_counter_bench.sv
`timescale 1ns/1ps
module modwrap_counter_bench;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         clear_n = 1'b1, load_n = 1'b1, en_par = 1'b0, en_trk = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] q;
  logic         carry_out, wrap_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  modwrap_counter u_modwrap_counter (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .en_par(en_par),
    .en_trk(en_trk), .din(din), .q(q), .carry_out(carry_out), .wrap_flag(wrap_flag)
  );

  typedef struct { logic [W-1:0] val; string tag; } exp_t;
  exp_t sb[$];

  // Bench model of the count, advanced from the requirements.
  int unsigned mq = 0;

  function automatic void check1(string tag, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  // Driver: apply one edge's worth of controls, check same-cycle flags, queue next q.
  task automatic step(input logic c, input logic l, input logic ep, input logic et,
                      input int unsigned d, input string tag);
    int unsigned nx;
    exp_t e;
    @(negedge clk);
    clear_n = c; load_n = l; en_par = ep; en_trk = et; din = W'(d);
    #1;
    check1({tag, " R5 carry"}, carry_out, ((mq == 15) && et) ? 1 : 0);
    check1({tag, " R6 wrap"},  wrap_flag, (mq == 14) ? 1 : 0);
    if (!c || mq == 14)  nx = 0;
    else if (!l)         nx = d;
    else if (ep && et)   nx = (mq + 1) % 16;
    else                 nx = mq;
    mq = nx;
    e.val = W'(nx); e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compare q shortly after each rising edge.
  initial begin
    forever begin
      @(posedge clk); #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check1({e.tag, " q"}, q, e.val);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // Initial clear beats a pending load: R1
    @(negedge clk); clear_n = 0; load_n = 0; din = 4'd9; en_par = 1; en_trk = 1;
    @(posedge clk); #2;
    check1("R1 clear over load", q, 0);
    mq = 0;
    step(0, 0, 1, 1, 9, "R1");
    // Load with enables low: R2
    step(1, 0, 0, 0, 5, "R2");
    // Hold on either enable low: R3
    step(1, 1, 0, 1, 0, "R3 par low");
    step(1, 1, 1, 0, 0, "R3 trk low");
    // Increment: R4
    step(1, 1, 1, 1, 0, "R4");
    // Load 15 and observe carry gating, then rollover: R8 R5 R4
    step(1, 0, 1, 1, 15, "R8 load15");
    step(1, 1, 1, 0, 0, "R5 hold at 15");
    step(1, 1, 1, 1, 0, "R8 roll");
    // Terminal beats load: R6
    step(1, 0, 0, 0, 14, "R6 load14");
    step(1, 0, 0, 0, 3, "R6 wrap over load");
    // Clear then 100 counting cycles: R7
    step(0, 1, 1, 1, 0, "R7 clear");
    for (int i = 0; i < 100; i++) step(1, 1, 1, 1, 0, "R7 seq");
    @(negedge clk); en_par = 0; en_trk = 0;
    @(posedge clk); #3;
    check1("R7 final mod15", q, 100 % 15);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule